// File: doc/BRIEF.md
# Shared-Buffer Ownership Semaphore

This block decides who may touch a pair of transfer buffers that are shared between a local processor and an SPI slave engine. The processor asks for the buffers with a one-cycle acquire pulse and hands them back with a one-cycle release pulse. The SPI side claims the buffers when a chip-select transaction begins while nobody holds them. It gives them back when that transaction ends.

Ownership is held in a four-state machine that reports a 2-bit code. One of the four states records a processor request that is waiting for an SPI transaction to finish. Two sticky event flags are kept: one for transaction end and one for ownership granted to the processor. Each flag is cleared by its own pulse. An interrupt enable pair is written through separate set and clear masks and can be read back. The interrupt line combines the flags with those enables. A shortcut enable makes a transaction end re-acquire the buffers for the processor straight away.

Top module: `buf_own_sema`

## Requirements
- R1: After reset, the state code is 0, both event flags are 0, both interrupt enables are 0, `spi_grant` is 0 and `irq` is 0.
- R2: An acquire pulse while the state is 0 (free) gives state 1 (processor owns) on the next clock and sets the ACQUIRED flag. It wins over a transaction start in the same cycle.
- R3: A release pulse in state 1 gives state 0 on the next clock. A release pulse has no effect in states 0, 2 and 3.
- R4: A transaction start in state 0 with no acquire gives state 2 (SPI owns) and raises `spi_grant`. A transaction start in state 1 leaves state 1 and `spi_grant` at 0.
- R5: An acquire pulse in state 2 gives state 3 (SPI owns, handover to the processor pending) when no transaction end arrives in the same cycle. An acquire pulse in states 1 and 3 has no effect.
- R6: A transaction end in state 3 gives state 1 and sets the END and ACQUIRED flags together. A transaction end in state 2 with no acquire and the shortcut off gives state 0 and sets END only. A transaction end in state 0 or 1 sets no flag and leaves the state unchanged.
- R7: A transaction end in state 2 with `short_en` high, or with an acquire pulse in the same cycle, gives state 1 and sets both END and ACQUIRED.
- R8: Event flags are indexed bit 0 for END and bit 1 for ACQUIRED. A flag stays set until a clear pulse on its bit of `ev_clr`. If a flag is set and cleared in the same cycle, it ends up set.
- R9: Interrupt enables use the same bit indices as the flags. A 1 in `ien_set` sets that enable and a 1 in `ien_clr` clears it. If both are 1 for the same bit, that bit ends up set. `ien` reads back the current enables.
- R10: `irq` is high exactly when some flag and its matching enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_pulse | input | 1 | Processor acquire request, one cycle |
| rel_pulse | input | 1 | Processor release, one cycle |
| xfer_start | input | 1 | Chip-select transaction begins, one cycle |
| xfer_end | input | 1 | Chip-select transaction ends, one cycle |
| short_en | input | 1 | Re-acquire for the processor on transaction end |
| ev_clr | input | 2 | Flag clear pulses (bit 0 END, bit 1 ACQUIRED) |
| ien_set | input | 2 | Interrupt enable set mask |
| ien_clr | input | 2 | Interrupt enable clear mask |
| sem_state | output | 2 | Ownership code: 0 free, 1 processor, 2 SPI, 3 SPI with handover pending |
| spi_grant | output | 1 | SPI engine owns the buffers |
| ev_flags | output | 2 | Sticky event flags |
| ien | output | 2 | Current interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The state machine is swept over every starting state combined with all 32 combinations of acquire, release, start, end and shortcut in one cycle. The expected next state and flags are computed from the requirements. This separates the priorities between contending inputs, such as acquire against start or end against acquire against the shortcut, and it shows which inputs are ignored in each state. A second sweep covers every enable value against every flag-clear mask, which tells the interrupt gating apart from plain flag state. Directed sequences cover stickiness and the set-over-clear tie of both the flags and the enables.

// File: rtl/sema_pkg.sv
package sema_pkg;
    localparam int SEM_W  = 2;
    localparam int EV_N   = 2;
    localparam int EV_END = 0;
    localparam int EV_ACQ = 1;

    typedef enum logic [SEM_W-1:0] {
        ST_FREE = 2'd0,
        ST_CPU  = 2'd1,
        ST_SPI  = 2'd2,
        ST_PEND = 2'd3
    } sema_st_e;

    typedef struct packed {
        sema_st_e st;
    } fsm_regs_t;

    typedef struct packed {
        logic [EV_N-1:0] ev;
        logic [EV_N-1:0] en;
    } evt_regs_t;
endpackage

// File: rtl/sema_fsm.sv
module sema_fsm
    import sema_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acq_pulse,
    input  logic     rel_pulse,
    input  logic     xfer_start,
    input  logic     xfer_end,
    input  logic     short_en,
    output sema_st_e state_q,
    output logic     end_set,
    output logic     acq_set
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        end_set = 1'b0;
        acq_set = 1'b0;
        case (r_q.st)
            ST_FREE: begin
                if (acq_pulse) begin
                    r_d.st  = ST_CPU;
                    acq_set = 1'b1;
                end else if (xfer_start) begin
                    r_d.st = ST_SPI;
                end
            end
            ST_CPU: begin
                if (rel_pulse) r_d.st = ST_FREE;
            end
            ST_SPI: begin
                if (xfer_end) begin
                    end_set = 1'b1;
                    if (acq_pulse || short_en) begin
                        r_d.st  = ST_CPU;
                        acq_set = 1'b1;
                    end else begin
                        r_d.st = ST_FREE;
                    end
                end else if (acq_pulse) begin
                    r_d.st = ST_PEND;
                end
            end
            default: begin
                if (xfer_end) begin
                    r_d.st  = ST_CPU;
                    end_set = 1'b1;
                    acq_set = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= ST_FREE;
        else        r_q   <= r_d;
    end

    assign state_q = r_q.st;

    a_r2_acq_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && acq_pulse) |=> (state_q == ST_CPU));
    a_r4_cpu_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CPU && !rel_pulse) |=> (state_q == ST_CPU));
    a_r5_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPI && acq_pulse && !xfer_end) |=> (state_q == ST_PEND));
    a_r6_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && xfer_end) |=> (state_q == ST_CPU));
    a_r7_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPI && xfer_end && short_en) |=> (state_q == ST_CPU));
endmodule

// File: rtl/sema_evt.sv
module sema_evt
    import sema_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] ev_set,
    input  logic [EV_N-1:0] ev_clr,
    input  logic [EV_N-1:0] ien_set,
    input  logic [EV_N-1:0] ien_clr,
    output logic [EV_N-1:0] ev_q,
    output logic [EV_N-1:0] en_q,
    output logic            irq
);
    evt_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.ev = (r_q.ev & ~ev_clr) | ev_set;
        r_d.en = (r_q.en & ~ien_clr) | ien_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ev_q = r_q.ev;
    assign en_q = r_q.en;
    assign irq  = |(r_q.ev & r_q.en);

    for (genvar i = 0; i < EV_N; i++) begin : g_chk
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_q[i] && !ev_clr[i]) |=> ev_q[i]);
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[i] |=> ev_q[i]);
        a_r9_en_set: assert property (@(posedge clk) disable iff (!rst_n)
            ien_set[i] |=> en_q[i]);
        a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!ien_set[i] && !ien_clr[i]) |=> $stable(en_q[i]));
    end
endmodule

// File: rtl/buf_own_sema.sv
module buf_own_sema
    import sema_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_pulse,
    input  logic             rel_pulse,
    input  logic             xfer_start,
    input  logic             xfer_end,
    input  logic             short_en,
    input  logic [EV_N-1:0]  ev_clr,
    input  logic [EV_N-1:0]  ien_set,
    input  logic [EV_N-1:0]  ien_clr,
    output logic [SEM_W-1:0] sem_state,
    output logic             spi_grant,
    output logic [EV_N-1:0]  ev_flags,
    output logic [EV_N-1:0]  ien,
    output logic             irq
);
    sema_st_e        st;
    logic            end_set, acq_set;
    logic [EV_N-1:0] set_vec;

    sema_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .acq_pulse(acq_pulse), .rel_pulse(rel_pulse),
        .xfer_start(xfer_start), .xfer_end(xfer_end), .short_en(short_en),
        .state_q(st), .end_set(end_set), .acq_set(acq_set)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[EV_END] = end_set;
        set_vec[EV_ACQ] = acq_set;
    end

    sema_evt u_evt (
        .clk(clk), .rst_n(rst_n),
        .ev_set(set_vec), .ev_clr(ev_clr),
        .ien_set(ien_set), .ien_clr(ien_clr),
        .ev_q(ev_flags), .en_q(ien), .irq(irq)
    );

    assign sem_state = st;
    assign spi_grant = (st == ST_SPI) || (st == ST_PEND);

    a_r6_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_grant && xfer_end) |=> ev_flags[EV_END]);
    a_r4_grant_state: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_state == 2'd1 && xfer_start) |=> !spi_grant);
endmodule

// File: tb/buf_own_sema_bench.sv
module buf_own_sema_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acq_pulse = 0, rel_pulse = 0, xfer_start = 0, xfer_end = 0, short_en = 0;
    logic [1:0] ev_clr = 0, ien_set = 0, ien_clr = 0;
    logic [1:0] sem_state, ev_flags, ien;
    logic       spi_grant, irq;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    buf_own_sema u_buf_own_sema (
        .clk(clk), .rst_n(rst_n), .acq_pulse(acq_pulse), .rel_pulse(rel_pulse),
        .xfer_start(xfer_start), .xfer_end(xfer_end), .short_en(short_en),
        .ev_clr(ev_clr), .ien_set(ien_set), .ien_clr(ien_clr),
        .sem_state(sem_state), .spi_grant(spi_grant), .ev_flags(ev_flags),
        .ien(ien), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        acq_pulse = 0; rel_pulse = 0; xfer_start = 0; xfer_end = 0; short_en = 0;
        ev_clr = 0; ien_set = 0; ien_clr = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        rst_n = 0; idle();
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    task automatic go_state(input int s);
        do_reset();
        if (s == 1) begin acq_pulse = 1; step(); end
        if (s >= 2) begin xfer_start = 1; step(); end
        if (s == 3) begin acq_pulse = 1; step(); end
        ev_clr = 2'b11; step();
    endtask

    function automatic int exp_next(input int s, input bit a, r, st, e, sh);
        case (s)
            0: return a ? 1 : (st ? 2 : 0);
            1: return r ? 0 : 1;
            2: return e ? ((a || sh) ? 1 : 0) : (a ? 3 : 2);
            default: return e ? 1 : 3;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R1 reset state
        check("R1 state", sem_state, 0);
        check("R1 flags", ev_flags, 0);
        check("R1 ien", ien, 0);
        check("R1 irq", irq, 0);
        check("R1 grant", spi_grant, 0);

        // Exhaustive one-cycle sweep: covers R2 R3 R4 R5 R6 R7
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 32; c++) begin
                int  nx, fe, fa;
                go_state(s);
                acq_pulse = c[0]; rel_pulse = c[1]; xfer_start = c[2];
                xfer_end = c[3]; short_en = c[4];
                step();
                nx = exp_next(s, c[0], c[1], c[2], c[3], c[4]);
                fe = (c[3] && s >= 2) ? 1 : 0;
                fa = (nx == 1 && s != 1) ? 1 : 0;
                check("sweep R2 R3 R4 R5 R6 R7 state", sem_state, nx);
                check("sweep R6 END flag", ev_flags[0], fe);
                check("sweep R2 R7 ACQUIRED flag", ev_flags[1], fa);
                check("sweep R4 grant", spi_grant, (nx >= 2) ? 1 : 0);
            end
        end

        // R8 stickiness and set-over-clear
        do_reset();
        acq_pulse = 1; step();
        repeat (5) step();
        check("R8 sticky ACQUIRED", ev_flags, 2'b10);
        ev_clr = 2'b01; step();
        check("R8 clear other bit no effect", ev_flags, 2'b10);
        ev_clr = 2'b10; step();
        check("R8 clear", ev_flags, 2'b00);
        rel_pulse = 1; step();
        acq_pulse = 1; ev_clr = 2'b10; step();
        check("R8 set wins over clear", ev_flags, 2'b10);

        // R9 enable set/clear masks
        do_reset();
        ien_set = 2'b01; step();
        check("R9 set bit0", ien, 2'b01);
        ien_set = 2'b10; step();
        check("R9 set bit1", ien, 2'b11);
        ien_clr = 2'b01; step();
        check("R9 clear bit0", ien, 2'b10);
        ien_set = 2'b01; ien_clr = 2'b01; step();
        check("R9 set wins", ien, 2'b11);
        repeat (3) step();
        check("R9 hold", ien, 2'b11);

        // R10 irq over every enable value and every flag-clear mask
        for (int en = 0; en < 4; en++) begin
            for (int cm = 0; cm < 4; cm++) begin
                do_reset();
                xfer_start = 1; step();
                acq_pulse = 1; step();
                xfer_end = 1; ien_set = en[1:0]; step();
                check("R10 both flags", ev_flags, 2'b11);
                ev_clr = cm[1:0]; step();
                check("R10 irq", irq, ((~cm & en & 3) != 0) ? 1 : 0);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule